// File: doc/BRIEF.md
# E-Paper Panel Scan Timing Generator

This block produces the horizontal and vertical scan strobes for an electrophoretic panel. It runs in the source-clock domain: one count per source clock along a line, one count per line down a frame. Each axis has four programmable segments: sync, back porch, data and end. From these the block derives sync pulses, active-area flags, a source-data enable window, a gate-clock pulse placed relative to the start of each line, a line-flag event, and column and row indices in the programmed scan direction.

A drive sequence covers a programmed number of frames. A rising edge on the start input while the block is idle launches the sequence. The block repeats the full frame scan until the last frame ends. It pulses frame end at the close of every frame and pulses display end together with the frame end of the final frame, then returns to idle. All strobes stay low while idle. Pixel fetch, waveform lookup and clock division are outside this block.

Top module: `epd_timing_gen`

## Requirements
- R1: After reset the block is idle. Every strobe, flag and pulse output is 0, and frame_idx is 0. While idle these outputs stay 0.
- R2: In a running sequence the line position counts 0 to (h_sync_len+h_back_len+h_data_len+h_end_len)-1 and then wraps. hsync is 1 exactly while the position is below h_sync_len, so hsync rises at position 0.
- R3: h_active is 1 exactly for positions from h_sync_len+h_back_len up to that value plus h_data_len, exclusive.
- R4: The row counter steps once per line wrap and counts 0 to (v_sync_len+v_back_len+v_data_len+v_end_len)-1. vsync is 1 while the row is below v_sync_len. v_active is 1 for rows from v_sync_len+v_back_len up to that value plus v_data_len, exclusive.
- R5: gate_clk is 1 for line positions from gate_rise up to gate_rise+gate_len, exclusive. Positions count from the hsync rising edge, which is position 0.
- R6: sde is 1 only in v_active rows, for line positions starting at h_sync_len+h_back_len. It lasts sde_width clocks, or h_data_len clocks when sde_width is 0.
- R7: A sequence runs frame_last+1 frames. frame_end is a one-clock pulse at the last position of the last row of each frame. frame_idx starts at 0 and increments after each frame that is not the final one.
- R8: disp_end pulses in the same clock as the frame_end of frame number frame_last. From the next clock the block is idle.
- R9: Only a 0-to-1 transition of start while idle launches a sequence. A start held high after a sequence ends does not relaunch it. A rising start during a sequence has no effect on the scan.
- R10: line_flag is a one-clock pulse at position 0 of row line_flag_num, in every frame.
- R11: Inside the active area, col_idx is the offset from the horizontal active start. When src_dir is 1 it is mirrored to h_data_len-1-offset. row_idx is the offset from the vertical active start, mirrored to v_data_len-1-offset when gate_dir is 1. Both indices are 0 outside the active area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sequence request; its rising edge launches a sequence while idle |
| frame_last | input | FW | Number of drive frames minus one |
| h_sync_len | input | H_W | Horizontal sync length in clocks |
| h_back_len | input | H_W | Horizontal back porch in clocks |
| h_data_len | input | H_W | Horizontal data length in clocks |
| h_end_len | input | H_W | Horizontal end length in clocks |
| v_sync_len | input | V_W | Vertical sync length in lines |
| v_back_len | input | V_W | Vertical back porch in lines |
| v_data_len | input | V_W | Vertical data length in lines |
| v_end_len | input | V_W | Vertical end length in lines |
| gate_rise | input | H_W | Gate-clock rising position from the hsync rise |
| gate_len | input | H_W | Gate-clock high time in clocks |
| sde_width | input | SDW | Source-data enable width; 0 selects h_data_len |
| line_flag_num | input | V_W | Row on which line_flag fires |
| gate_dir | input | 1 | 1 mirrors row_idx (bottom to top) |
| src_dir | input | 1 | 1 mirrors col_idx (right to left) |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| h_active | output | 1 | Horizontal active area |
| v_active | output | 1 | Vertical active area |
| sde | output | 1 | Source-data enable window |
| gate_clk | output | 1 | Gate clock pulse |
| line_flag | output | 1 | Line-match event pulse |
| col_idx | output | H_W+2 | Column index in scan order |
| row_idx | output | V_W+2 | Row index in scan order |
| frame_idx | output | FW | Current frame number |
| frame_end | output | 1 | Last clock of a frame |
| disp_end | output | 1 | Last clock of the sequence |

## Verification
The bench builds the block with H_W=6, V_W=5, FW=4 and SDW=4. With these widths a whole multi-frame sequence lasts only a few hundred clocks. The bench can therefore compare every output on every clock of complete sequences against a position model computed arithmetically from the clock count since launch. The configurations it runs cover the sde width at its default, below the data length and above it; gate pulses starting at the hsync rise and inside the line; mirrored and unmirrored indices; and line flags on the first and the last row. They also cover single-frame and three-frame sequences, start toggled during a run, and start held high after the end.

// File: rtl/epd_tg_pkg.sv
package epd_tg_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/epd_axis_cnt.sv
module epd_axis_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last_pos,
  output logic [W-1:0] pos,
  output logic         wrap
);
  assign wrap = (pos == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (clr)     pos <= '0;
    else if (step)    pos <= wrap ? '0 : pos + W'(1);
  end
endmodule

// File: rtl/epd_axis_decode.sv
module epd_axis_decode #(
  parameter int W  = 8,
  parameter int IW = 6
) (
  input  logic          en,
  input  logic [W-1:0]  pos,
  input  logic [IW-1:0] sync_len,
  input  logic [IW-1:0] back_len,
  input  logic [IW-1:0] data_len,
  input  logic          flip,
  output logic          sync_o,
  output logic          act_o,
  output logic [W-1:0]  idx_o
);
  function automatic logic [W-1:0] widen(input logic [IW-1:0] v);
    return W'(v);
  endfunction

  function automatic logic [W-1:0] mirror(input logic [W-1:0] off,
                                          input logic [W-1:0] len,
                                          input logic dir);
    return dir ? (len - W'(1) - off) : off;
  endfunction

  logic [W-1:0] act_lo;
  logic [W-1:0] off;

  assign act_lo = widen(sync_len) + widen(back_len);
  assign off    = pos - act_lo;
  assign sync_o = en && (pos < widen(sync_len));
  assign act_o  = en && (pos >= act_lo) && (off < widen(data_len));
  assign idx_o  = act_o ? mirror(off, widen(data_len), flip) : '0;
endmodule

// File: rtl/epd_window.sv
module epd_window #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] pos,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] len,
  output logic         hit
);
  // subtract before comparing so lo+len never overflows
  assign hit = en && (pos >= lo) && ((pos - lo) < len);
endmodule

// File: rtl/epd_seq_ctrl.sv
module epd_seq_ctrl
  import epd_tg_pkg::*;
#(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          line_wrap,
  input  logic          row_wrap,
  input  logic [FW-1:0] frame_last,
  output logic          run,
  output logic          launch,
  output logic [FW-1:0] frame_idx,
  output logic          frame_end,
  output logic          disp_end
);
  seq_state_t state_q;
  logic       start_q;

  assign run       = (state_q == SEQ_RUN);
  assign launch    = start && !start_q && !run;
  assign frame_end = run && line_wrap && row_wrap;
  assign disp_end  = frame_end && (frame_idx == frame_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      start_q   <= 1'b0;
      frame_idx <= '0;
    end else begin
      start_q <= start;
      if (launch) begin
        state_q   <= SEQ_RUN;
        frame_idx <= '0;
      end else if (disp_end) begin
        state_q <= SEQ_IDLE;
      end else if (frame_end) begin
        frame_idx <= frame_idx + FW'(1);
      end
    end
  end
endmodule

// File: rtl/epd_timing_gen.sv
module epd_timing_gen #(
  parameter int H_W = 12,
  parameter int V_W = 11,
  parameter int FW  = 8,
  parameter int SDW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  frame_last,
  input  logic [H_W-1:0] h_sync_len,
  input  logic [H_W-1:0] h_back_len,
  input  logic [H_W-1:0] h_data_len,
  input  logic [H_W-1:0] h_end_len,
  input  logic [V_W-1:0] v_sync_len,
  input  logic [V_W-1:0] v_back_len,
  input  logic [V_W-1:0] v_data_len,
  input  logic [V_W-1:0] v_end_len,
  input  logic [H_W-1:0] gate_rise,
  input  logic [H_W-1:0] gate_len,
  input  logic [SDW-1:0] sde_width,
  input  logic [V_W-1:0] line_flag_num,
  input  logic           gate_dir,
  input  logic           src_dir,
  output logic           hsync,
  output logic           vsync,
  output logic           h_active,
  output logic           v_active,
  output logic           sde,
  output logic           gate_clk,
  output logic           line_flag,
  output logic [H_W+1:0] col_idx,
  output logic [V_W+1:0] row_idx,
  output logic [FW-1:0]  frame_idx,
  output logic           frame_end,
  output logic           disp_end
);
  // two spare bits hold the sum of four segments without overflow
  localparam int HC_W = H_W + 2;
  localparam int VC_W = V_W + 2;

  function automatic logic [HC_W-1:0] h_last_pos(input logic [H_W-1:0] a, b, c, d);
    return HC_W'(a) + HC_W'(b) + HC_W'(c) + HC_W'(d) - HC_W'(1);
  endfunction

  function automatic logic [VC_W-1:0] v_last_pos(input logic [V_W-1:0] a, b, c, d);
    return VC_W'(a) + VC_W'(b) + VC_W'(c) + VC_W'(d) - VC_W'(1);
  endfunction

  logic            seq_run;
  logic            seq_launch;
  logic [HC_W-1:0] hpos;
  logic [VC_W-1:0] vpos;
  logic            line_wrap;
  logic            row_wrap;
  logic [HC_W-1:0] h_lo;
  logic [HC_W-1:0] sde_len;

  epd_seq_ctrl #(.FW(FW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .line_wrap  (line_wrap),
    .row_wrap   (row_wrap),
    .frame_last (frame_last),
    .run        (seq_run),
    .launch     (seq_launch),
    .frame_idx  (frame_idx),
    .frame_end  (frame_end),
    .disp_end   (disp_end)
  );

  epd_axis_cnt #(.W(HC_W)) u_hcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (seq_launch),
    .step     (seq_run),
    .last_pos (h_last_pos(h_sync_len, h_back_len, h_data_len, h_end_len)),
    .pos      (hpos),
    .wrap     (line_wrap)
  );

  epd_axis_cnt #(.W(VC_W)) u_vcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (seq_launch),
    .step     (seq_run && line_wrap),
    .last_pos (v_last_pos(v_sync_len, v_back_len, v_data_len, v_end_len)),
    .pos      (vpos),
    .wrap     (row_wrap)
  );

  epd_axis_decode #(.W(HC_W), .IW(H_W)) u_hdec (
    .en       (seq_run),
    .pos      (hpos),
    .sync_len (h_sync_len),
    .back_len (h_back_len),
    .data_len (h_data_len),
    .flip     (src_dir),
    .sync_o   (hsync),
    .act_o    (h_active),
    .idx_o    (col_idx)
  );

  epd_axis_decode #(.W(VC_W), .IW(V_W)) u_vdec (
    .en       (seq_run),
    .pos      (vpos),
    .sync_len (v_sync_len),
    .back_len (v_back_len),
    .data_len (v_data_len),
    .flip     (gate_dir),
    .sync_o   (vsync),
    .act_o    (v_active),
    .idx_o    (row_idx)
  );

  assign h_lo    = HC_W'(h_sync_len) + HC_W'(h_back_len);
  assign sde_len = (sde_width == '0) ? HC_W'(h_data_len) : HC_W'(sde_width);

  epd_window #(.W(HC_W)) u_sde (
    .en  (v_active),
    .pos (hpos),
    .lo  (h_lo),
    .len (sde_len),
    .hit (sde)
  );

  epd_window #(.W(HC_W)) u_gate (
    .en  (seq_run),
    .pos (hpos),
    .lo  (HC_W'(gate_rise)),
    .len (HC_W'(gate_len)),
    .hit (gate_clk)
  );

  assign line_flag = seq_run && (hpos == '0) && (vpos == VC_W'(line_flag_num));
endmodule

// File: rtl/epd_timing_gen_chk.sv
module epd_timing_gen_chk #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          hsync,
  input logic          vsync,
  input logic          sde,
  input logic          gate_clk,
  input logic          line_flag,
  input logic          v_active,
  input logic [FW-1:0] frame_idx,
  input logic [FW-1:0] frame_last,
  input logic          frame_end,
  input logic          disp_end
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(hsync || vsync || sde || gate_clk || line_flag || frame_end || disp_end));

  a_r6_sde_in_rows: assert property (@(posedge clk) disable iff (!rst_n)
    sde |-> v_active);

  a_r7_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (frame_idx <= frame_last));

  a_r8_end_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    disp_end |-> (frame_end && frame_idx == frame_last));

  a_r8_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    disp_end |=> !run);

  a_r9_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> (run && $stable(frame_idx)));
endmodule

bind epd_timing_gen epd_timing_gen_chk #(.FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (seq_run),
  .hsync      (hsync),
  .vsync      (vsync),
  .sde        (sde),
  .gate_clk   (gate_clk),
  .line_flag  (line_flag),
  .v_active   (v_active),
  .frame_idx  (frame_idx),
  .frame_last (frame_last),
  .frame_end  (frame_end),
  .disp_end   (disp_end)
);

// File: tb/sim_epd_timing_gen.sv
`timescale 1ns/1ps
module sim_epd_timing_gen;
  localparam int H_W = 6;
  localparam int V_W = 5;
  localparam int FW  = 4;
  localparam int SDW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0]  frame_last = '0;
  logic [H_W-1:0] h_sync_len = '0, h_back_len = '0, h_data_len = '0, h_end_len = '0;
  logic [V_W-1:0] v_sync_len = '0, v_back_len = '0, v_data_len = '0, v_end_len = '0;
  logic [H_W-1:0] gate_rise = '0, gate_len = '0;
  logic [SDW-1:0] sde_width = '0;
  logic [V_W-1:0] line_flag_num = '0;
  logic gate_dir = 1'b0, src_dir = 1'b0;
  logic hsync, vsync, h_active, v_active, sde, gate_clk, line_flag, frame_end, disp_end;
  logic [H_W+1:0] col_idx;
  logic [V_W+1:0] row_idx;
  logic [FW-1:0]  frame_idx;

  always #2 clk = ~clk;

  epd_timing_gen #(.H_W(H_W), .V_W(V_W), .FW(FW), .SDW(SDW)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  int c_hs, c_hb, c_hd, c_he, c_vs, c_vb, c_vd, c_ve;
  int c_gr, c_gl, c_sw, c_lf, c_fl, c_gd, c_sd;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg();
    h_sync_len = H_W'(c_hs); h_back_len = H_W'(c_hb);
    h_data_len = H_W'(c_hd); h_end_len  = H_W'(c_he);
    v_sync_len = V_W'(c_vs); v_back_len = V_W'(c_vb);
    v_data_len = V_W'(c_vd); v_end_len  = V_W'(c_ve);
    gate_rise = H_W'(c_gr); gate_len = H_W'(c_gl);
    sde_width = SDW'(c_sw); line_flag_num = V_W'(c_lf);
    frame_last = FW'(c_fl); gate_dir = c_gd[0]; src_dir = c_sd[0];
  endtask

  task automatic check_idle(input string req);
    chk({req, " idle strobes"},
        int'({hsync, vsync, h_active, v_active, sde, gate_clk, line_flag, frame_end, disp_end}), 0);
  endtask

  task automatic check_cycle(input int t);
    int ht, vt, h, v, f, lo, vlo, sw, ha, va, e_col, e_row, fe;
    ht = c_hs + c_hb + c_hd + c_he;
    vt = c_vs + c_vb + c_vd + c_ve;
    h = t % ht; v = (t / ht) % vt; f = t / (ht * vt);
    lo = c_hs + c_hb; vlo = c_vs + c_vb;
    sw = (c_sw == 0) ? c_hd : c_sw;
    ha = (h >= lo && h < lo + c_hd) ? 1 : 0;
    va = (v >= vlo && v < vlo + c_vd) ? 1 : 0;
    e_col = ha ? (c_sd != 0 ? c_hd - 1 - (h - lo) : h - lo) : 0;
    e_row = va ? (c_gd != 0 ? c_vd - 1 - (v - vlo) : v - vlo) : 0;
    fe = (h == ht - 1 && v == vt - 1) ? 1 : 0;
    chk("R2 hsync", int'(hsync), (h < c_hs) ? 1 : 0);
    chk("R3 h_active", int'(h_active), ha);
    chk("R4 vsync/v_active", int'({vsync, v_active}), ((v < c_vs) ? 2 : 0) + va);
    chk("R5 gate_clk", int'(gate_clk), (h >= c_gr && h < c_gr + c_gl) ? 1 : 0);
    chk("R6 sde", int'(sde), (va != 0 && h >= lo && h < lo + sw) ? 1 : 0);
    chk("R7 frame_end/frame_idx", int'(frame_end) * 256 + int'(frame_idx), fe * 256 + f);
    chk("R8 disp_end", int'(disp_end), (fe != 0 && f == c_fl) ? 1 : 0);
    chk("R10 line_flag", int'(line_flag), (h == 0 && v == c_lf) ? 1 : 0);
    chk("R11 col_idx/row_idx", int'(col_idx) * 1024 + int'(row_idx), e_col * 1024 + e_row);
  endtask

  // one full sequence; optional start toggle during the run (R9)
  task automatic run_seq(input bit toggle);
    int total;
    total = (c_hs + c_hb + c_hd + c_he) * (c_vs + c_vb + c_vd + c_ve) * (c_fl + 1);
    @(negedge clk); start = 1'b0; apply_cfg();
    @(negedge clk); check_idle("R1 before launch");
    start = 1'b1;
    @(posedge clk);
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      check_cycle(t);
      if (toggle && t == 5)  start = 1'b0;
      if (toggle && t == 20) start = 1'b1;
    end
    @(negedge clk); check_idle("R8 after end");
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); check_idle("R9 start held");
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    chk("R1 frame_idx", int'(frame_idx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 idle no start");

    c_hs = 2; c_hb = 3; c_hd = 5; c_he = 2; c_vs = 1; c_vb = 2; c_vd = 3; c_ve = 1;
    c_gr = 1; c_gl = 4; c_sw = 0; c_lf = 3; c_fl = 2; c_gd = 0; c_sd = 0;
    run_seq(1'b0);

    c_hs = 3; c_hb = 2; c_hd = 6; c_he = 1; c_vs = 2; c_vb = 1; c_vd = 4; c_ve = 2;
    c_gr = 4; c_gl = 2; c_sw = 3; c_lf = 0; c_fl = 0; c_gd = 1; c_sd = 1;
    run_seq(1'b1);

    c_hs = 1; c_hb = 1; c_hd = 4; c_he = 3; c_vs = 2; c_vb = 1; c_vd = 2; c_ve = 2;
    c_gr = 0; c_gl = 3; c_sw = 6; c_lf = 6; c_fl = 1; c_gd = 1; c_sd = 0;
    run_seq(1'b1);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule